// File: doc/BRIEF.md
# Auxiliary Clock-Gating Enable Qualifier

This block holds the software-programmed enables for five auxiliary clock-gating domains. It turns them into the gate-enable signals that the clock cells consume. The five domains are:

- the frame timer while the links sit in U2;
- USB2 port clock throttling;
- the host engine clock;
- the power-management block clock;
- the USB3 clock trunk.

Each enable is qualified by its domain's own condition. A dynamic-gating-disable fuse masks the engine, power-management and trunk enables, but it does not change what software reads back.

The configuration bits sit in their own reset domain, which has a dedicated reset input, so a reset of the main logic leaves them intact. The qualified enables are registered, so each gate output changes only on a clock edge. The trunk gate additionally requires every USB3 port and every USB3 PHY instance to report its auxiliary clock as already gated. The port count and the PHY count are parameters.

Top module: `clk_gate_qual`

## Requirements
- R1: While `cfg_rst_ni` is low, all configuration bits are 0 and `rd_data_o` reads 0x00. While `rst_ni` is low, all five gate outputs are 0.
- R2: A write with `wr_en_i` high loads the enables on the next edge. The bit positions are 7 for frame timer, 6 for USB2 throttle, 5 for engine, 4 for power-management block and 3 for trunk. Bits 2:0 always read 0.
- R3: `rd_data_o[7:3]` returns exactly the last written value of those bits, whatever the state of `fuse_dcg_dis_i`.
- R4: While `fuse_dcg_dis_i` is 1, `eng_gate_o`, `pm_gate_o` and `trunk_gate_o` are 0 one cycle later, whatever their enable bits are.
- R5: `eng_gate_o` equals, one cycle later, bit 5 AND `eng_idle_i` AND NOT fuse.
- R6: `pm_gate_o` equals, one cycle later, bit 4 AND `pm_idle_i` AND NOT fuse.
- R7: `trunk_gate_o` equals, one cycle later, bit 3 AND NOT fuse AND every bit of `port_gated_i` AND every bit of `phy_gated_i`.
- R8: `ftmr_gate_o` equals, one cycle later, bit 7 AND `u2_i`. The fuse has no effect on it.
- R9: `usb2_thr_o` equals, one cycle later, bit 6. The fuse has no effect on it.
- R10: Pulsing `rst_ni` low while `cfg_rst_ni` stays high leaves the configuration bits and the readback unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset, main logic |
| cfg_rst_ni | input | 1 | Active-low async reset, configuration bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register readback |
| fuse_dcg_dis_i | input | 1 | Dynamic clock-gating disable fuse |
| u2_i | input | 1 | Ports are in U2 |
| eng_idle_i | input | 1 | Host engine idle |
| pm_idle_i | input | 1 | Power-management block idle |
| port_gated_i | input | N_PORT | Per-USB3-port aux clock gated |
| phy_gated_i | input | N_PHY | Per-PHY aux clock gated |
| ftmr_gate_o | output | 1 | Frame timer gate enable |
| usb2_thr_o | output | 1 | USB2 port throttle enable |
| eng_gate_o | output | 1 | Host engine gate enable |
| pm_gate_o | output | 1 | Power-management block gate enable |
| trunk_gate_o | output | 1 | USB3 clock trunk gate enable |

## Verification
The checker examines each asserted gate output on every cycle. It confirms that the previous cycle's domain condition held: idle for the engine and power-management block, U2 for the frame timer, and all ports and PHYs gated for the trunk. It also confirms that the fuse was clear for the three fused domains, that a write shows up in the readback, and that the reserved bits read 0.

The bench's scenarios cover the rest:
- the split between the two reset domains;
- readback that ignores the fuse;
- a trunk held off by a single port or PHY that is not yet gated;
- gates that deassert as soon as a condition drops.

// File: rtl/cgq_pkg.sv
package cgq_pkg;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned BIT_FTMR  = 7;
  localparam int unsigned BIT_USB2  = 6;
  localparam int unsigned BIT_ENG   = 5;
  localparam int unsigned BIT_PM    = 4;
  localparam int unsigned BIT_TRUNK = 3;

  typedef struct packed {
    logic ftmr;
    logic usb2;
    logic eng;
    logic pm;
    logic trunk;
  } gate_vec_t;
endpackage

// File: rtl/cgq_cfg_reg.sv
module cgq_cfg_reg
  import cgq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CFG_W-1:0] wr_data_i,
  output logic [CFG_W-1:0] rd_data_o,
  output gate_vec_t        en_o
);
  localparam logic [CFG_W-1:0] WR_MASK = CFG_W'((1 << BIT_FTMR) | (1 << BIT_USB2) |
                                                (1 << BIT_ENG)  | (1 << BIT_PM)   |
                                                (1 << BIT_TRUNK));

  logic [CFG_W-1:0] cfg_q;

  for (genvar b = 0; b < CFG_W; b++) begin : g_bit
    if (WR_MASK[b]) begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cfg_q[b] <= 1'b0;
        else if (wr_en_i) cfg_q[b] <= wr_data_i[b];
      end
    end else begin : g_rsvd
      assign cfg_q[b] = 1'b0;
    end
  end

  // readback is raw: fuse never applied here
  assign rd_data_o = cfg_q;

  assign en_o.ftmr  = cfg_q[BIT_FTMR];
  assign en_o.usb2  = cfg_q[BIT_USB2];
  assign en_o.eng   = cfg_q[BIT_ENG];
  assign en_o.pm    = cfg_q[BIT_PM];
  assign en_o.trunk = cfg_q[BIT_TRUNK];
endmodule

// File: rtl/cgq_all_gated.sv
module cgq_all_gated #(
  parameter int unsigned N = 4
) (
  input  logic [(N > 0 ? N : 1)-1:0] vec_i,
  output logic                       all_o
);
  if (N == 0) begin : g_none
    logic unused;
    assign unused = vec_i[0];
    assign all_o  = 1'b1;
  end else begin : g_red
    assign all_o = &vec_i;
  end
endmodule

// File: rtl/cgq_qual.sv
module cgq_qual
  import cgq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  gate_vec_t en_i,
  input  logic      fuse_dis_i,
  input  logic      u2_i,
  input  logic      eng_idle_i,
  input  logic      pm_idle_i,
  input  logic      ports_all_i,
  input  logic      phys_all_i,
  output gate_vec_t gate_o
);
  gate_vec_t gate_d, gate_q;

  always_comb begin
    gate_d.ftmr  = en_i.ftmr & u2_i;
    gate_d.usb2  = en_i.usb2;
    gate_d.eng   = en_i.eng   & eng_idle_i & ~fuse_dis_i;
    gate_d.pm    = en_i.pm    & pm_idle_i  & ~fuse_dis_i;
    gate_d.trunk = en_i.trunk & ports_all_i & phys_all_i & ~fuse_dis_i;
  end

  // registered so gate enables move only on an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= gate_d;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/clk_gate_qual.sv
module clk_gate_qual
  import cgq_pkg::*;
#(
  parameter int unsigned N_PORT = 4,
  parameter int unsigned N_PHY  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_rst_ni,
  input  logic              wr_en_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  input  logic              fuse_dcg_dis_i,
  input  logic              u2_i,
  input  logic              eng_idle_i,
  input  logic              pm_idle_i,
  input  logic [N_PORT-1:0] port_gated_i,
  input  logic [N_PHY-1:0]  phy_gated_i,
  output logic              ftmr_gate_o,
  output logic              usb2_thr_o,
  output logic              eng_gate_o,
  output logic              pm_gate_o,
  output logic              trunk_gate_o
);
  gate_vec_t en, gate;
  logic      ports_all, phys_all;

  cgq_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (cfg_rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .en_o      (en)
  );

  cgq_all_gated #(.N(N_PORT)) u_ports (.vec_i(port_gated_i), .all_o(ports_all));
  cgq_all_gated #(.N(N_PHY))  u_phys  (.vec_i(phy_gated_i),  .all_o(phys_all));

  cgq_qual u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .fuse_dis_i  (fuse_dcg_dis_i),
    .u2_i        (u2_i),
    .eng_idle_i  (eng_idle_i),
    .pm_idle_i   (pm_idle_i),
    .ports_all_i (ports_all),
    .phys_all_i  (phys_all),
    .gate_o      (gate)
  );

  assign ftmr_gate_o  = gate.ftmr;
  assign usb2_thr_o   = gate.usb2;
  assign eng_gate_o   = gate.eng;
  assign pm_gate_o    = gate.pm;
  assign trunk_gate_o = gate.trunk;
endmodule

// File: rtl/clk_gate_qual_chk.sv
module clk_gate_qual_chk #(
  parameter int unsigned N_PORT = 4,
  parameter int unsigned N_PHY  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_rst_ni,
  input logic              wr_en_i,
  input logic [7:0]        wr_data_i,
  input logic [7:0]        rd_data_o,
  input logic              fuse_dcg_dis_i,
  input logic              u2_i,
  input logic              eng_idle_i,
  input logic              pm_idle_i,
  input logic [N_PORT-1:0] port_gated_i,
  input logic [N_PHY-1:0]  phy_gated_i,
  input logic              ftmr_gate_o,
  input logic              eng_gate_o,
  input logic              pm_gate_o,
  input logic              trunk_gate_o
);
  // R4
  fuse_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !cfg_rst_ni)
    (eng_gate_o || pm_gate_o || trunk_gate_o) |-> !$past(fuse_dcg_dis_i));

  // R5
  eng_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !cfg_rst_ni)
    eng_gate_o |-> $past(eng_idle_i));

  // R6
  pm_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !cfg_rst_ni)
    pm_gate_o |-> $past(pm_idle_i));

  // R7
  trunk_all_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !cfg_rst_ni)
    trunk_gate_o |-> $past((&port_gated_i) && (&phy_gated_i)));

  // R8
  ftmr_u2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !cfg_rst_ni)
    ftmr_gate_o |-> $past(u2_i));

  // R3
  readback_chk: assert property (@(posedge clk_i) disable iff (!cfg_rst_ni)
    wr_en_i |=> rd_data_o[7:3] == $past(wr_data_i[7:3]));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!cfg_rst_ni)
    rd_data_o[2:0] == 3'b000);
endmodule

bind clk_gate_qual clk_gate_qual_chk #(.N_PORT(N_PORT), .N_PHY(N_PHY)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_rst_ni     (cfg_rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .rd_data_o      (rd_data_o),
  .fuse_dcg_dis_i (fuse_dcg_dis_i),
  .u2_i           (u2_i),
  .eng_idle_i     (eng_idle_i),
  .pm_idle_i      (pm_idle_i),
  .port_gated_i   (port_gated_i),
  .phy_gated_i    (phy_gated_i),
  .ftmr_gate_o    (ftmr_gate_o),
  .eng_gate_o     (eng_gate_o),
  .pm_gate_o      (pm_gate_o),
  .trunk_gate_o   (trunk_gate_o)
);

// File: tb/clk_gate_qual_tb_top.sv
module clk_gate_qual_tb_top;
  localparam int N_PORT = 4;
  localparam int N_PHY  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, cfg_rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic fuse = 1'b0, u2 = 1'b0, eng_idle = 1'b0, pm_idle = 1'b0;
  logic [N_PORT-1:0] port_g = '0;
  logic [N_PHY-1:0]  phy_g = '0;
  logic ftmr_o, usb2_o, eng_o, pm_o, trunk_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] shadow = '0;

  always #2ns clk = ~clk;

  clk_gate_qual #(.N_PORT(N_PORT), .N_PHY(N_PHY)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_rst_ni(cfg_rst_ni),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .fuse_dcg_dis_i(fuse), .u2_i(u2), .eng_idle_i(eng_idle), .pm_idle_i(pm_idle),
    .port_gated_i(port_g), .phy_gated_i(phy_g),
    .ftmr_gate_o(ftmr_o), .usb2_thr_o(usb2_o), .eng_gate_o(eng_o),
    .pm_gate_o(pm_o), .trunk_gate_o(trunk_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, predict, compare at next negedge
  task automatic step(input logic w, input logic [7:0] wd, input logic f, input logic u,
                      input logic ei, input logic pi, input logic [N_PORT-1:0] pg,
                      input logic [N_PHY-1:0] hg);
    logic e_ftmr, e_usb2, e_eng, e_pm, e_trunk;
    wr_en = w; wr_data = wd; fuse = f; u2 = u; eng_idle = ei; pm_idle = pi;
    port_g = pg; phy_g = hg;
    e_ftmr  = shadow[7] && u;
    e_usb2  = shadow[6];
    e_eng   = shadow[5] && ei && !f;
    e_pm    = shadow[4] && pi && !f;
    e_trunk = shadow[3] && !f && (pg == '1) && (hg == '1);
    if (w) shadow = wd & 8'hF8;
    @(posedge clk);
    @(negedge clk);
    chk("R8 ftmr_gate", {7'd0, ftmr_o}, {7'd0, e_ftmr});
    chk("R9 usb2_thr", {7'd0, usb2_o}, {7'd0, e_usb2});
    chk(f ? "R4 eng_gate fused" : "R5 eng_gate", {7'd0, eng_o}, {7'd0, e_eng});
    chk(f ? "R4 pm_gate fused" : "R6 pm_gate", {7'd0, pm_o}, {7'd0, e_pm});
    chk(f ? "R4 trunk_gate fused" : "R7 trunk_gate", {7'd0, trunk_o}, {7'd0, e_trunk});
    chk(f ? "R3 readback under fuse" : "R2 readback", rd_data, shadow);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 rd_data in cfg reset", rd_data, 8'h00);
    chk("R1 gates in reset", {3'd0, ftmr_o, usb2_o, eng_o, pm_o, trunk_o}, 8'h00);
    rst_ni = 1'b1; cfg_rst_ni = 1'b1;
    @(negedge clk);

    // R2: all bits, reserved read zero
    step(1, 8'hFF, 0, 1, 1, 1, '1, '1);
    step(0, 8'h00, 0, 1, 1, 1, '1, '1);
    chk("R2 reserved bits zero", {5'd0, rd_data[2:0]}, 8'h00);
    // R4/R3: fuse masks three enables, readback intact
    step(0, 8'h00, 1, 1, 1, 1, '1, '1);
    step(0, 8'h00, 1, 1, 1, 1, '1, '1);
    chk("R3 readback ignores fuse", rd_data, 8'hF8);
    // R7: one port or one phy short
    step(0, 8'h00, 0, 1, 1, 1, 4'b1110, '1);
    step(0, 8'h00, 0, 1, 1, 1, '1, 2'b01);
    step(0, 8'h00, 0, 1, 1, 1, '1, '1);
    // R5/R6/R8: conditions drop
    step(0, 8'h00, 0, 0, 0, 1, '1, '1);
    step(0, 8'h00, 0, 1, 1, 0, '1, '1);
    // single-bit enables
    step(1, 8'h20, 0, 1, 1, 1, '1, '1);
    step(1, 8'h08, 0, 1, 1, 1, '1, '1);
    step(1, 8'h40, 1, 0, 0, 0, '0, '0);
    step(1, 8'h90, 0, 1, 1, 1, '1, '1);
    step(0, 8'h00, 0, 1, 1, 1, '1, '1);

    // R10: main reset keeps configuration
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R10 cfg kept in main reset", rd_data, 8'h90);
    chk("R1 gates low in main reset", {3'd0, ftmr_o, usb2_o, eng_o, pm_o, trunk_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    step(0, 8'h00, 0, 1, 1, 1, '1, '1);

    // R1: cfg reset clears register
    cfg_rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 cfg reset clears", rd_data, 8'h00);
    cfg_rst_ni = 1'b1; shadow = '0;
    @(negedge clk);
    step(0, 8'h00, 0, 1, 1, 1, '1, '1);

    // mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[15:8], r[2] & r[3], r[4], r[5], r[6],
           (r[7] ? '1 : N_PORT'(r[19:16])), (r[20] ? '1 : N_PHY'(r[22:21])));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule